// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port with GPIO Bank

This block is a configuration window on a small 8-bit register bus. It has two neighbouring bus locations. Offset 0 is the index port and offset 1 is the data port. No register can be reached until software writes an unlock key to the index port twice in a row. After the unlock, an index-port write selects a configuration register, and the data port then reads or writes the selected register.

One register selects the active logical device bank. The GPIO bank holds three registers for an 8-bit pin port:
- a direction register,
- an output latch,
- a read-only view of the synchronised pin levels.

Writing a lock value to the index port closes the window again.

A typical session writes the key twice, then selects the GPIO bank through the device-select register. It then sets directions, drives outputs or samples inputs, and finally relocks the block.

Top module: `keyCfgPort`

## Requirements
- R1: After reset the block is locked, all pins are inputs (`gpioOe` = 0x00), `gpioOut` = 0x00, the bank select and index are 0x00, and `busRdata` = 0xFF.
- R2: Two index-port writes of 0x87 in a row unlock the block. Any other index-port write, or any data-port write, between the two restarts the key search.
- R3: While locked, data-port writes change nothing, and any read (index or data port) returns 0xFF.
- R4: Writing 0xAA to the index port while unlocked relocks the block and leaves the stored index unchanged.
- R5: Index 0x07 is the bank-select register: a data write stores the byte and a data read returns it, whatever bank is active.
- R6: The GPIO registers respond only while the bank select holds 0x06. With any other bank, writes to 0x80/0x81 are ignored and reads of them return 0x00.
- R7: Index 0x80 is the direction register. Bit n set makes pin n an output, bit n clear makes it an input, and `gpioOe` equals this register.
- R8: Index 0x81 is the output latch and reads back as written. `gpioOut[n]` equals latch bit n where direction bit n is 1, and is 0 elsewhere.
- R9: Index 0x82 returns the pin levels (high = 1) after a two-flop synchroniser, so a read issued two or more cycles after a pin change shows it. Writes to 0x82 are ignored.
- R10: While unlocked, an index-port read returns the stored index, and a data read of an index with no register returns 0x00.
- R11: `busRdata` takes its new value at the clock edge that samples `busRd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Port select: 0 index port, 1 data port |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| gpioOut | output | 8 | Pin output values |
| gpioOe | output | 8 | Pin output enables |
| gpioIn | input | 8 | Pin input levels, asynchronous |

## Verification
Read data is due one clock edge after the read strobe. Register writes show on `gpioOe` and `gpioOut` at the same edge as the write strobe, and unlock or relock takes effect for the very next access. A pin change reaches the register view only after two edges, so the bench waits three cycles after changing `gpioIn` before reading index 0x82. The bench drives every access on a falling edge and samples on the next falling edge, which is half a cycle after the edge that registers the result. No sample can therefore race the update.

// File: rtl/keyCfgPkg.sv
package keyCfgPkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_t;

  typedef enum logic [2:0] {
    RSEL_FF    = 3'd0,
    RSEL_INDEX = 3'd1,
    RSEL_LDN   = 3'd2,
    RSEL_DIR   = 3'd3,
    RSEL_OUT   = 3'd4,
    RSEL_PIN   = 3'd5,
    RSEL_ZERO  = 3'd6
  } rdSel_t;

  typedef struct packed {
    logic   wrLdn;
    logic   wrDir;
    logic   wrOut;
    logic   rdEn;
    rdSel_t rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/keyCfgCtrl.sv
module keyCfgCtrl
  import keyCfgPkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] KEY_VAL  = 8'h87,
  parameter logic [PORT_W-1:0] LOCK_VAL = 8'hAA,
  parameter logic [PORT_W-1:0] LDN_IDX  = 8'h07,
  parameter logic [PORT_W-1:0] GPIO_LDN = 8'h06,
  parameter logic [PORT_W-1:0] DIR_IDX  = 8'h80,
  parameter logic [PORT_W-1:0] OUT_IDX  = 8'h81,
  parameter logic [PORT_W-1:0] PIN_IDX  = 8'h82
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PORT_W-1:0] busWdata,
  input  logic [PORT_W-1:0] ldnCur,
  output cfgStrobe_t        strobe,
  output keyState_t         keyState,
  output logic [PORT_W-1:0] idxReg
);

  logic isIdxWr, isDatWr, unlocked, gpioSel;
  keyState_t keyNext;

  assign isIdxWr  = busWr && !busSel;
  assign isDatWr  = busWr && busSel;
  assign unlocked = (keyState == KEY_OPEN);
  assign gpioSel  = (ldnCur == GPIO_LDN);

  // key sequencer: two back-to-back key writes open, lock value closes
  always_comb begin
    keyNext = keyState;
    unique case (keyState)
      KEY_LOCKED: if (isIdxWr && busWdata == KEY_VAL) keyNext = KEY_HALF;
      KEY_HALF: begin
        if (isIdxWr)      keyNext = (busWdata == KEY_VAL) ? KEY_OPEN : KEY_LOCKED;
        else if (isDatWr) keyNext = KEY_LOCKED;
      end
      KEY_OPEN:   if (isIdxWr && busWdata == LOCK_VAL) keyNext = KEY_LOCKED;
      default:    keyNext = KEY_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= KEY_LOCKED;
      idxReg   <= '0;
    end else begin
      keyState <= keyNext;
      if (unlocked && isIdxWr && busWdata != LOCK_VAL) idxReg <= busWdata;
    end
  end

  // index decode into strobes for the datapath
  always_comb begin
    strobe       = '0;
    strobe.rdSel = RSEL_FF;
    strobe.rdEn  = busRd;
    if (unlocked && isDatWr) begin
      if (idxReg == LDN_IDX)      strobe.wrLdn = 1'b1;
      else if (gpioSel) begin
        if (idxReg == DIR_IDX)    strobe.wrDir = 1'b1;
        if (idxReg == OUT_IDX)    strobe.wrOut = 1'b1;
      end
    end
    if (!unlocked)                            strobe.rdSel = RSEL_FF;
    else if (!busSel)                         strobe.rdSel = RSEL_INDEX;
    else if (idxReg == LDN_IDX)               strobe.rdSel = RSEL_LDN;
    else if (gpioSel && idxReg == DIR_IDX)    strobe.rdSel = RSEL_DIR;
    else if (gpioSel && idxReg == OUT_IDX)    strobe.rdSel = RSEL_OUT;
    else if (gpioSel && idxReg == PIN_IDX)    strobe.rdSel = RSEL_PIN;
    else                                      strobe.rdSel = RSEL_ZERO;
  end

endmodule

// File: rtl/keyCfgDatapath.sv
module keyCfgDatapath
  import keyCfgPkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [PORT_W-1:0] busWdata,
  input  logic [PORT_W-1:0] idxReg,
  input  logic [PORT_W-1:0] gpioIn,
  output logic [PORT_W-1:0] ldnCur,
  output logic [PORT_W-1:0] busRdata,
  output logic [PORT_W-1:0] gpioOut,
  output logic [PORT_W-1:0] gpioOe
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [PORT_W-1:0] dirReg, outReg, pinLevel;
  logic [PORT_W-1:0] syncPipe [SYNC_STAGES];

  // pin synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN)      syncPipe[s] <= '0;
      else if (s == 0) syncPipe[s] <= gpioIn;
      else            syncPipe[s] <= syncPipe[(s == 0) ? 0 : s - 1];
    end
  end
  assign pinLevel = syncPipe[LAST_STAGE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnCur <= '0;
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (strobe.wrLdn) ldnCur <= busWdata;
      if (strobe.wrDir) dirReg <= busWdata;
      if (strobe.wrOut) outReg <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '1;
    else if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        RSEL_FF:    busRdata <= '1;
        RSEL_INDEX: busRdata <= idxReg;
        RSEL_LDN:   busRdata <= ldnCur;
        RSEL_DIR:   busRdata <= dirReg;
        RSEL_OUT:   busRdata <= outReg;
        RSEL_PIN:   busRdata <= pinLevel;
        default:    busRdata <= '0;
      endcase
    end
  end

  assign gpioOe = dirReg;
  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    assign gpioOut[b] = dirReg[b] ? outReg[b] : 1'b0;
  end

endmodule

// File: rtl/keyCfgPort.sv
module keyCfgPort
  import keyCfgPkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] KEY_VAL  = 8'h87,
  parameter logic [PORT_W-1:0] LOCK_VAL = 8'hAA,
  parameter logic [PORT_W-1:0] LDN_IDX  = 8'h07,
  parameter logic [PORT_W-1:0] GPIO_LDN = 8'h06,
  parameter logic [PORT_W-1:0] DIR_IDX  = 8'h80,
  parameter logic [PORT_W-1:0] OUT_IDX  = 8'h81,
  parameter logic [PORT_W-1:0] PIN_IDX  = 8'h82
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  output logic [PORT_W-1:0] gpioOut,
  output logic [PORT_W-1:0] gpioOe,
  input  logic [PORT_W-1:0] gpioIn
);

  cfgStrobe_t        strobe;
  keyState_t         keyState;
  logic [PORT_W-1:0] idxReg, ldnCur;

  keyCfgCtrl #(
    .PORT_W(PORT_W), .KEY_VAL(KEY_VAL), .LOCK_VAL(LOCK_VAL), .LDN_IDX(LDN_IDX),
    .GPIO_LDN(GPIO_LDN), .DIR_IDX(DIR_IDX), .OUT_IDX(OUT_IDX), .PIN_IDX(PIN_IDX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .ldnCur(ldnCur), .strobe(strobe),
    .keyState(keyState), .idxReg(idxReg)
  );

  keyCfgDatapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .idxReg(idxReg), .gpioIn(gpioIn), .ldnCur(ldnCur), .busRdata(busRdata),
    .gpioOut(gpioOut), .gpioOe(gpioOe)
  );

endmodule

// File: rtl/keyCfgChecker.sv
module keyCfgChecker
  import keyCfgPkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] KEY_VAL  = 8'h87,
  parameter logic [PORT_W-1:0] LOCK_VAL = 8'hAA
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic              busRd,
  input logic [PORT_W-1:0] busWdata,
  input logic [PORT_W-1:0] busRdata,
  input logic [PORT_W-1:0] gpioOut,
  input logic [PORT_W-1:0] gpioOe,
  input keyState_t         keyState
);

  assert_key_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_HALF && busWr && !busSel && busWdata == KEY_VAL)
      |=> (keyState == KEY_OPEN));

  assert_key_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_HALF && busWr && (busSel || busWdata != KEY_VAL))
      |=> (keyState == KEY_LOCKED));

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && keyState != KEY_OPEN) |=> (busRdata == '1));

  assert_relock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_OPEN && busWr && !busSel && busWdata == LOCK_VAL)
      |=> (keyState == KEY_LOCKED));

  assert_pins_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busSel && keyState == KEY_OPEN)
      |=> ($stable(gpioOe) && $stable(gpioOut)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

endmodule

bind keyCfgPort keyCfgChecker #(.PORT_W(PORT_W), .KEY_VAL(KEY_VAL), .LOCK_VAL(LOCK_VAL))
  i_keyCfgChecker (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .gpioOut(gpioOut),
    .gpioOe(gpioOe), .keyState(keyState)
  );

// File: tb/test_keyCfgPort.sv
`timescale 1ns/1ps
module test_keyCfgPort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, busRdata, gpioOut, gpioOe, gpioIn = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model of the register file
  bit         mOpen = 0, mHalf = 0;
  logic [7:0] mIdx = 0, mLdn = 0, mDir = 0, mOut = 0, mPins = 0;

  always #2 clk = ~clk;

  keyCfgPort i_keyCfgPort (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .gpioOut(gpioOut),
    .gpioOe(gpioOe), .gpioIn(gpioIn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic sel, input logic wr, input logic rd, input logic [7:0] wd);
    @(negedge clk);
    busSel = sel; busWr = wr; busRd = rd; busWdata = wd;
    @(negedge clk);
    busWr = 0; busRd = 0;
  endtask

  task automatic wrIdx(input logic [7:0] v);
    busCycle(1'b0, 1'b1, 1'b0, v);
    if (mOpen) begin
      if (v == 8'hAA) mOpen = 0; else mIdx = v;
    end else if (v == 8'h87) begin
      if (mHalf) begin mOpen = 1; mHalf = 0; end else mHalf = 1;
    end else mHalf = 0;
  endtask

  task automatic wrData(input logic [7:0] v);
    busCycle(1'b1, 1'b1, 1'b0, v);
    if (!mOpen) mHalf = 0;
    else if (mIdx == 8'h07) mLdn = v;
    else if (mLdn == 8'h06 && mIdx == 8'h80) mDir = v;
    else if (mLdn == 8'h06 && mIdx == 8'h81) mOut = v;
  endtask

  task automatic rdPort(input logic sel, output logic [7:0] v);
    busCycle(sel, 1'b0, 1'b1, 8'h00);
    v = busRdata;
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    gpioIn = v;
    repeat (3) @(negedge clk);
    mPins = v;
  endtask

  function automatic logic [7:0] expData();
    if (!mOpen) return 8'hFF;
    if (mIdx == 8'h07) return mLdn;
    if (mLdn == 8'h06) begin
      if (mIdx == 8'h80) return mDir;
      if (mIdx == 8'h81) return mOut;
      if (mIdx == 8'h82) return mPins;
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] expIdx();
    return mOpen ? mIdx : 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv, hold;
    logic [7:0] idxPick [8] = '{8'h87, 8'hAA, 8'h07, 8'h80, 8'h81, 8'h82, 8'h90, 8'h00};
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", gpioOe, 8'h00);
    chk("R1 out", gpioOut, 8'h00);
    chk("R1 rdata", busRdata, 8'hFF);

    // R3 locked: reads FF, data writes ignored
    rdPort(1'b1, rv); chk("R3 locked data read", rv, 8'hFF);
    rdPort(1'b0, rv); chk("R3 locked index read", rv, 8'hFF);
    wrData(8'h06);

    // R2 interrupted key sequences stay locked
    wrIdx(8'h87); wrIdx(8'h12); wrIdx(8'h87);
    rdPort(1'b1, rv); chk("R2 broken by index write", rv, 8'hFF);
    wrData(8'h33); wrIdx(8'h87);
    rdPort(1'b1, rv); chk("R2 broken by data write", rv, 8'hFF);
    wrIdx(8'h87);
    rdPort(1'b0, rv); chk("R2 open, R10 index read", rv, 8'h00);

    // R5 bank select; R3 the locked write left it at 0
    wrIdx(8'h07);
    rdPort(1'b1, rv); chk("R3 locked write ignored", rv, 8'h00);
    wrData(8'h05);
    rdPort(1'b1, rv); chk("R5 bank readback", rv, 8'h05);

    // R6 GPIO registers hidden in another bank
    wrIdx(8'h80); wrData(8'hFF);
    rdPort(1'b1, rv); chk("R6 other bank read", rv, 8'h00);
    chk("R6 other bank oe", gpioOe, 8'h00);

    // R7 / R8 direction and output
    wrIdx(8'h07); wrData(8'h06);
    wrIdx(8'h80); wrData(8'hF0);
    chk("R7 oe", gpioOe, 8'hF0);
    wrIdx(8'h81); wrData(8'h5A);
    chk("R8 masked out", gpioOut, 8'h50);
    rdPort(1'b1, rv); chk("R8 latch readback", rv, 8'h5A);

    // R9 pins through synchronizer, read-only
    setPins(8'hA5);
    wrIdx(8'h82);
    rdPort(1'b1, rv); chk("R9 pin read", rv, 8'hA5);
    wrData(8'h00);
    rdPort(1'b1, rv); chk("R9 write ignored", rv, 8'hA5);

    // R10 unimplemented index
    wrIdx(8'h90);
    rdPort(1'b1, rv); chk("R10 empty index", rv, 8'h00);

    // R4 relock keeps index
    wrIdx(8'hAA);
    rdPort(1'b1, rv); chk("R4 relocked data", rv, 8'hFF);
    wrIdx(8'h87); wrIdx(8'h87);
    rdPort(1'b0, rv); chk("R4 index kept", rv, 8'h90);

    // R11 read data holds while idle
    hold = busRdata;
    repeat (3) @(negedge clk);
    chk("R11 hold", busRdata, hold);

    // random phase against the model
    for (int n = 0; n < 800; n++) begin
      case ($urandom % 7)
        0, 1: wrIdx(idxPick[$urandom % 8]);
        2:    wrData(8'($urandom));
        3:    begin rdPort(1'b1, rv); chk("R5 R6 R9 R10 random data read", rv, expData()); end
        4:    begin rdPort(1'b0, rv); chk("R3 R10 random index read", rv, expIdx()); end
        5:    setPins(8'($urandom));
        default: begin
          if (!mOpen) begin wrIdx(8'h87); wrIdx(8'h87); end
          wrIdx(8'h07); wrData(8'h06);
        end
      endcase
      chk("R7 random oe", gpioOe, mDir);
      chk("R8 random out", gpioOut, mOut & mDir);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule